// File: doc/BRIEF.md
# Radix Page Table Walker

This block resolves an effective address into a real address by descending a tree of translation tables held in memory. Each table slot is one 64-bit word, fetched through a plain read port: a one-cycle request with an address, then a response strobe with the data. The caller supplies the effective address, the root table base, the root index width and the total translated address width, and pulses a start strobe. The walker then reads one slot per level. Each non-leaf slot names the next table and that table's index width. The walk stops at a leaf slot or at the first fault.

A walk ends in one of two ways. On success, a one-cycle completion pulse comes with the real address, the resulting page size in bits and the leaf word. On failure, a one-cycle fault pulse comes with a cause code. Before each level's read, the walker checks the tree shape against a fixed set of allowed index widths per level. A table base whose low bits are not aligned to the table's size is realigned without raising a fault.

Top module: `radix_walker`

## Requirements
- R1: The first read address is the root base plus 8 times the root index, where the root index is `ea >> (addr_size - root_isz)` masked to `root_isz` bits.
- R2: Before any base is used (root or next-level), its low `isz + 3` bits are cleared, and no fault is raised for them.
- R3: Level 0 is accepted only when `addr_size` is 52 and the index width is 13. Otherwise the walk ends with fault cause 1 (bad configuration) and issues no read.
- R4: Levels 1 and 2 accept only index width 9, level 3 accepts 9 or 5, and level 4 or deeper is never accepted. A rejected level ends the walk with fault cause 1 before that level's read.
- R5: A slot whose bit 63 (valid) is 0 ends the walk with fault cause 2 (missing entry).
- R6: After each slot is read, the remaining size drops by the current index width. For a valid slot with bit 62 (leaf) clear, bits 4:0 give the next index width and bits 55:8 give the next base (other bits zero). The next read goes to that base (realigned) plus 8 times `(ea >> (remaining - next_isz))` masked to `next_isz` bits.
- R7: For a valid slot with bit 62 set, `real_addr` takes slot bits 55:12 that lie at or above the remaining size, and takes `ea` bits below the remaining size. `page_size` equals the remaining size and `leaf_pte` equals the slot. A successful walk can only end with a page size of 39, 30, 21, 16 or 12.
- R8: `rd_req` is high for exactly one cycle per read. No new read is requested while one is outstanding.
- R9: `done` and `fault` are single-cycle pulses that never coincide. `fault_cause` is 0 except alongside `fault`. A `start` that arrives while a walk is in progress is ignored and does not alter that walk's result.
- R10: While reset is asserted and directly after it, `rd_req`, `done` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a walk (accepted only when idle) |
| ea | input | 64 | Effective address to translate |
| root_base | input | 64 | Base address of the root table |
| root_isz | input | 5 | Index width of the root table |
| addr_size | input | 7 | Total translated address width |
| rd_req | output | 1 | Memory read request, one cycle |
| rd_addr | output | 64 | Memory read address |
| rd_valid | input | 1 | Memory read response strobe |
| rd_data | input | 64 | Memory read response word |
| done | output | 1 | Walk completed successfully (pulse) |
| fault | output | 1 | Walk stopped with a fault (pulse) |
| fault_cause | output | 2 | 1 = bad configuration, 2 = missing entry, 0 otherwise |
| real_addr | output | 64 | Translated real address, held after `done` |
| page_size | output | 7 | Page size in address bits, held after `done` |
| leaf_pte | output | 64 | Leaf slot word, held after `done` |

## Verification
The assertions assume that memory answers each request exactly once, with a single-cycle `rd_valid` that arrives at least one cycle after the request and never without one. They also assume that a fault for a bad configuration can only follow a cycle with no response. The bench's memory responder meets this: it records each request, waits zero to two extra cycles chosen at random, and then returns one word from a table that is built for that walk. Walks are randomised in effective address, base misalignment, leaf depth and final-level index width, and some carry an injected invalid slot or an illegal index width. Directed cases cover the root shape checks, the walk that passes level 3 into level 4, and a start pulse issued while a walk is in progress.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;
  parameter int AW        = 64;
  parameter int ISZ_W     = 5;
  parameter int SZ_W      = 7;
  parameter int LVL_W     = 3;
  parameter int ROOT_SIZE = 52;
  parameter int ROOT_ISZ  = 13;
  parameter int MID_ISZ   = 9;
  parameter int ALT_ISZ   = 5;
  parameter int LAST_LVL  = 3;

  localparam int VALID_BIT = AW - 1;
  localparam int LEAF_BIT  = AW - 2;

  localparam logic [AW-1:0] NEXT_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [AW-1:0] PAGE_NUM_MASK  = 64'h00FF_FFFF_FFFF_F000;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BADCFG = 2'd1,
    CAUSE_NOPTE  = 2'd2
  } cause_e;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_CHECK = 2'd1,
    W_WAIT  = 2'd2
  } wstate_e;
endpackage

// File: rtl/radix_cfg_check.sv
module radix_cfg_check
  import radix_walk_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic [SZ_W-1:0]  remaining,
  input  logic [ISZ_W-1:0] isz,
  output logic             cfg_ok
);
  localparam logic [SZ_W-1:0]  RootSz  = SZ_W'(ROOT_SIZE);
  localparam logic [ISZ_W-1:0] RootIsz = ISZ_W'(ROOT_ISZ);
  localparam logic [ISZ_W-1:0] MidIsz  = ISZ_W'(MID_ISZ);
  localparam logic [ISZ_W-1:0] AltIsz  = ISZ_W'(ALT_ISZ);

  always_comb begin
    if (level == '0) begin
      cfg_ok = (remaining == RootSz) && (isz == RootIsz);
    end else if (level < LVL_W'(LAST_LVL)) begin
      cfg_ok = (isz == MidIsz);
    end else if (level == LVL_W'(LAST_LVL)) begin
      cfg_ok = (isz == MidIsz) || (isz == AltIsz);
    end else begin
      cfg_ok = 1'b0;
    end
  end
endmodule

// File: rtl/radix_slot_addr.sv
module radix_slot_addr
  import radix_walk_pkg::*;
(
  input  logic [AW-1:0]    ea,
  input  logic [AW-1:0]    base,
  input  logic [SZ_W-1:0]  remaining,
  input  logic [ISZ_W-1:0] isz,
  output logic [AW-1:0]    slot_addr
);
  localparam logic [AW-1:0] One = {{(AW-1){1'b0}}, 1'b1};

  logic [SZ_W-1:0] shift_amt;
  logic [SZ_W-1:0] align_bits;
  logic [AW-1:0]   idx_mask;
  logic [AW-1:0]   align_mask;
  logic [AW-1:0]   idx;

  always_comb begin
    shift_amt  = remaining - {{(SZ_W-ISZ_W){1'b0}}, isz};
    align_bits = {{(SZ_W-ISZ_W){1'b0}}, isz} + SZ_W'(3);
    idx_mask   = (One << isz) - One;
    align_mask = (One << align_bits) - One;
    idx        = (ea >> shift_amt) & idx_mask;
    slot_addr  = (base & ~align_mask) + {idx[AW-4:0], 3'b000};
  end
endmodule

// File: rtl/radix_leaf_form.sv
module radix_leaf_form
  import radix_walk_pkg::*;
(
  input  logic [AW-1:0]   pte,
  input  logic [AW-1:0]   ea,
  input  logic [SZ_W-1:0] remaining,
  output logic [AW-1:0]   real_addr
);
  localparam logic [AW-1:0] One = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] low_mask;

  always_comb begin
    low_mask  = (One << remaining) - One;
    real_addr = (pte & PAGE_NUM_MASK & ~low_mask) | (ea & low_mask);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      ea,
  input  logic [63:0]      root_base,
  input  logic [4:0]       root_isz,
  input  logic [6:0]       addr_size,
  output logic             rd_req,
  output logic [63:0]      rd_addr,
  input  logic             rd_valid,
  input  logic [63:0]      rd_data,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_cause,
  output logic [63:0]      real_addr,
  output logic [6:0]       page_size,
  output logic [63:0]      leaf_pte
);
  wstate_e          state_q, state_d;
  logic [AW-1:0]    ea_q, ea_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [SZ_W-1:0]  rem_q, rem_d;
  logic [ISZ_W-1:0] isz_q, isz_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             done_q, done_d;
  logic             fault_q, fault_d;
  cause_e           cause_q, cause_d;
  logic [AW-1:0]    ra_q, ra_d;
  logic [SZ_W-1:0]  psize_q, psize_d;
  logic [AW-1:0]    pte_q, pte_d;
  logic             res_en;

  // Shared datapath: one slot calculator, muxed between root start and next level
  logic             in_idle;
  logic [SZ_W-1:0]  rem_after;
  logic [ISZ_W-1:0] next_isz;
  logic [AW-1:0]    s_ea, s_base, slot;
  logic [SZ_W-1:0]  s_rem;
  logic [ISZ_W-1:0] s_isz;
  logic             cfg_ok;
  logic [AW-1:0]    leaf_ra;

  assign in_idle   = (state_q == W_IDLE);
  assign rem_after = rem_q - {{(SZ_W-ISZ_W){1'b0}}, isz_q};
  assign next_isz  = rd_data[ISZ_W-1:0];
  assign s_ea      = in_idle ? ea        : ea_q;
  assign s_base    = in_idle ? root_base : (rd_data & NEXT_BASE_MASK);
  assign s_rem     = in_idle ? addr_size : rem_after;
  assign s_isz     = in_idle ? root_isz  : next_isz;

  radix_slot_addr u_slot (
    .ea(s_ea), .base(s_base), .remaining(s_rem), .isz(s_isz), .slot_addr(slot)
  );

  radix_cfg_check u_cfg (
    .level(lvl_q), .remaining(rem_q), .isz(isz_q), .cfg_ok(cfg_ok)
  );

  radix_leaf_form u_leaf (
    .pte(rd_data), .ea(ea_q), .remaining(rem_after), .real_addr(leaf_ra)
  );

  always_comb begin
    state_d = state_q;
    ea_d    = ea_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    isz_d   = isz_q;
    lvl_d   = lvl_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    cause_d = CAUSE_NONE;
    ra_d    = ra_q;
    psize_d = psize_q;
    pte_d   = pte_q;
    res_en  = 1'b0;
    rd_req  = 1'b0;
    unique case (state_q)
      W_IDLE: begin
        if (start) begin
          ea_d    = ea;
          rem_d   = addr_size;
          isz_d   = root_isz;
          lvl_d   = '0;
          addr_d  = slot;
          state_d = W_CHECK;
        end
      end
      W_CHECK: begin
        if (cfg_ok) begin
          rd_req  = 1'b1;
          state_d = W_WAIT;
        end else begin
          fault_d = 1'b1;
          cause_d = CAUSE_BADCFG;
          state_d = W_IDLE;
        end
      end
      W_WAIT: begin
        if (rd_valid) begin
          if (!rd_data[VALID_BIT]) begin
            fault_d = 1'b1;
            cause_d = CAUSE_NOPTE;
            state_d = W_IDLE;
          end else if (rd_data[LEAF_BIT]) begin
            res_en  = 1'b1;
            ra_d    = leaf_ra;
            psize_d = rem_after;
            pte_d   = rd_data;
            done_d  = 1'b1;
            state_d = W_IDLE;
          end else begin
            rem_d   = rem_after;
            isz_d   = next_isz;
            lvl_d   = (lvl_q == '1) ? lvl_q : lvl_q + LVL_W'(1);
            addr_d  = slot;
            state_d = W_CHECK;
          end
        end
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      ea_q    <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      isz_q   <= '0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      ea_q    <= ea_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      isz_q   <= isz_d;
      lvl_q   <= lvl_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q    <= '0;
      psize_q <= '0;
      pte_q   <= '0;
    end else if (res_en) begin
      ra_q    <= ra_d;
      psize_q <= psize_d;
      pte_q   <= pte_d;
    end
  end

  assign rd_addr     = addr_q;
  assign done        = done_q;
  assign fault       = fault_q;
  assign fault_cause = cause_q;
  assign real_addr   = ra_q;
  assign page_size   = psize_q;
  assign leaf_pte    = pte_q;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        rd_valid,
  input logic [63:0] rd_data,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_cause,
  input logic [6:0]  page_size
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outst_q <= 1'b0;
    else if (rd_valid) outst_q <= 1'b0;
    else if (rd_req)   outst_q <= 1'b1;
  end

  // R10: quiet outputs during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (!rd_req && !done && !fault);
    end
  end

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !outst_q);
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fault_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  p_cause_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> fault_cause == 2'd0);
  p_badcfg_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_cause == 2'd1) |-> !$past(rd_valid));
  p_nopte_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_cause == 2'd2) |-> ($past(rd_valid) && !$past(rd_data[63])));
  p_leaf_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (page_size == 7'd39 || page_size == 7'd30 || page_size == 7'd21 ||
              page_size == 7'd16 || page_size == 7'd12));
endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
  .rd_data(rd_data), .done(done), .fault(fault),
  .fault_cause(fault_cause), .page_size(page_size)
);

// File: tb/tb_radix_walker.sv
`timescale 1ns/1ps
module tb_radix_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ea = '0;
  logic [63:0] root_base = '0;
  logic [4:0]  root_isz = '0;
  logic [6:0]  addr_size = '0;
  logic        rd_req;
  logic [63:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic        done, fault;
  logic [1:0]  fault_cause;
  logic [63:0] real_addr;
  logic [6:0]  page_size;
  logic [63:0] leaf_pte;

  always #4 clk = ~clk;

  radix_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .root_base(root_base),
    .root_isz(root_isz), .addr_size(addr_size), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fault(fault),
    .fault_cause(fault_cause), .real_addr(real_addr), .page_size(page_size),
    .leaf_pte(leaf_pte)
  );

  int checks = 0;
  int errors = 0;
  int overlap_err = 0;

  // memory table and request log
  logic [63:0] tbl_a [0:7];
  logic [63:0] tbl_d [0:7];
  int          tbl_n;
  logic [63:0] log_a [0:7];
  int          log_n;

  // expected outcome: 0 done, 1 bad config, 2 missing entry
  int          exp_kind;
  logic [63:0] exp_ra, exp_pte;
  int          exp_ps;
  logic [63:0] exp_a [0:7];
  int          exp_n;

  localparam logic [63:0] BASE_M = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] PAGE_M = 64'h00FF_FFFF_FFFF_F000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] b_mask(input int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [63:0] b_slot(input logic [63:0] e, input logic [63:0] b,
                                         input int rem, input int isz);
    logic [63:0] idx;
    idx = (e >> (rem - isz)) & b_mask(isz);
    return (b & ~b_mask(isz + 3)) + idx * 64'd8;
  endfunction

  function automatic bit b_cfg(input int lvl, input int rem, input int isz);
    if (lvl == 0) return (rem == 52) && (isz == 13);
    if (lvl == 1 || lvl == 2) return isz == 9;
    if (lvl == 3) return (isz == 9) || (isz == 5);
    return 1'b0;
  endfunction

  function automatic logic [63:0] lookup(input logic [63:0] a);
    for (int i = 0; i < tbl_n; i++) if (tbl_a[i] == a) return tbl_d[i];
    return 64'd0;
  endfunction

  // memory responder: random 0..2 extra cycles of latency
  initial begin
    bit          pend = 0;
    int          cnt = 0;
    logic [63:0] paddr = '0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (pend) begin
        if (rd_req) overlap_err++;
        if (cnt == 0) begin
          rd_valid = 1'b1;
          rd_data  = lookup(paddr);
          pend     = 0;
        end else cnt--;
      end else if (rd_req) begin
        pend  = 1;
        paddr = rd_addr;
        cnt   = int'($urandom % 3);
        if (log_n < 8) log_a[log_n] = rd_addr;
        log_n++;
      end
    end
  end

  // build table and expected result (inj: 0 none, 1 invalid slot, 2 illegal width)
  task automatic gen_walk(input logic [63:0] e, input logic [63:0] b, input int isz0,
                          input int asz, input int leaf_lvl, input int inj,
                          input int inj_lvl);
    int rem = asz, isz = isz0, nls;
    logic [63:0] base = b, a, d;
    tbl_n = 0; exp_n = 0; exp_kind = 1;
    for (int lvl = 0; lvl < 6; lvl++) begin
      if (!b_cfg(lvl, rem, isz)) begin exp_kind = 1; break; end
      a = b_slot(e, base, rem, isz);
      exp_a[exp_n] = a; exp_n++;
      rem = rem - isz;
      if (inj == 1 && lvl == inj_lvl) begin
        d = {$urandom, $urandom} & ~(64'd1 << 63);
        tbl_a[tbl_n] = a; tbl_d[tbl_n] = d; tbl_n++;
        exp_kind = 2; break;
      end
      if (lvl == leaf_lvl) begin
        d = {2'b11, $urandom, $urandom} ;
        d = d | (64'd3 << 62);
        tbl_a[tbl_n] = a; tbl_d[tbl_n] = d; tbl_n++;
        exp_kind = 0;
        exp_pte  = d;
        exp_ps   = rem;
        exp_ra   = (d & PAGE_M & ~b_mask(rem)) | (e & b_mask(rem));
        break;
      end
      nls = (lvl == 2 && ($urandom % 2 == 1)) ? 5 : 9;
      if (inj == 2 && lvl == inj_lvl) nls = 7;
      d = (64'd1 << 63) | ({$urandom, $urandom} & BASE_M) | 64'(nls);
      tbl_a[tbl_n] = a; tbl_d[tbl_n] = d; tbl_n++;
      base = d & BASE_M;
      isz  = nls;
    end
  endtask

  task automatic run_walk(input logic [63:0] e, input logic [63:0] b, input int isz0,
                          input int asz, input bit interfere);
    bit got = 0;
    log_n = 0;
    @(negedge clk);
    ea = e; root_base = b; root_isz = 5'(isz0); addr_size = 7'(asz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (interfere) begin
      @(negedge clk);
      ea = ~e; root_base = ~b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 400; i++) begin
      if (done || fault) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R9 walk ended", 64'(got), 64'd1);
    if (!got) return;
    chk(log_n == exp_n, "R8 read count", 64'(log_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < log_n && i < 8; i++)
      chk(log_a[i] == exp_a[i], (i == 0) ? "R1/R2 first read address" : "R6 next read address",
          log_a[i], exp_a[i]);
    if (exp_kind == 0) begin
      chk(done && !fault, interfere ? "R9 result with ignored start" : "R7 completion",
          {fault, done}, 64'd1);
      chk(real_addr == exp_ra, "R7 real address", real_addr, exp_ra);
      chk(page_size == 7'(exp_ps), "R7 page size", 64'(page_size), 64'(exp_ps));
      chk(leaf_pte == exp_pte, "R7 leaf word", leaf_pte, exp_pte);
      chk(fault_cause == 2'd0, "R9 cause clear on done", 64'(fault_cause), 64'd0);
    end else begin
      chk(fault && !done, (exp_kind == 1) ? "R3/R4 fault raised" : "R5 fault raised",
          {fault, done}, 64'd2);
      chk(fault_cause == 2'(exp_kind), (exp_kind == 1) ? "R4 bad-config cause" : "R5 missing-entry cause",
          64'(fault_cause), 64'(exp_kind));
    end
    @(negedge clk);
    chk(!done && !fault, "R9 single-cycle pulse", {fault, done}, 64'd0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] e, b;
    void'($urandom(32'd7741));
    tbl_n = 0; log_n = 0;
    repeat (3) @(negedge clk);
    chk(!rd_req && !done && !fault, "R10 outputs in reset", {rd_req, done, fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req && !done && !fault, "R10 outputs after reset", {rd_req, done, fault}, 64'd0);

    // R3: wrong total size, wrong root width
    gen_walk(64'h1234_5678_9ABC_DEF0, 64'h10_0000, 13, 48, 0, 0, 0);
    run_walk(64'h1234_5678_9ABC_DEF0, 64'h10_0000, 13, 48, 0);
    chk(log_n == 0, "R3 no read on bad root", 64'(log_n), 64'd0);
    gen_walk(64'h1234_5678_9ABC_DEF0, 64'h10_0000, 12, 52, 0, 0, 0);
    run_walk(64'h1234_5678_9ABC_DEF0, 64'h10_0000, 12, 52, 0);
    chk(log_n == 0, "R3 no read on bad width", 64'(log_n), 64'd0);

    // R2: misaligned root base, leaf at level 0
    e = 64'h000F_FFFF_FFFF_FFFF; b = 64'h0000_0040_0000_FFFF;
    gen_walk(e, b, 13, 52, 0, 0, 0);
    run_walk(e, b, 13, 52, 0);
    // full depth walk
    e = 64'h0008_A5A5_5A5A_1234; b = 64'h0002_0000_0000_0000;
    gen_walk(e, b, 13, 52, 3, 0, 0);
    run_walk(e, b, 13, 52, 0);
    // R4: non-leaf at level 3 runs into level 4
    gen_walk(e, b, 13, 52, 5, 0, 0);
    run_walk(e, b, 13, 52, 0);
    chk(log_n == 4, "R4 level 4 rejected before read", 64'(log_n), 64'd4);
    // R4: illegal width at level 1
    gen_walk(e, b, 13, 52, 3, 2, 0);
    run_walk(e, b, 13, 52, 0);
    // R5: invalid slot at level 2
    gen_walk(e, b, 13, 52, 3, 1, 2);
    run_walk(e, b, 13, 52, 0);
    // R9: start while busy is ignored
    gen_walk(e, b, 13, 52, 2, 0, 0);
    run_walk(e, b, 13, 52, 1);

    for (int n = 0; n < 120; n++) begin
      int leaf_lvl, inj, inj_lvl;
      e = {$urandom, $urandom};
      b = {$urandom, $urandom} & 64'h00FF_FFFF_FFFF_FFFF;
      leaf_lvl = int'($urandom % 5);
      inj      = ($urandom % 4 == 0) ? int'(1 + $urandom % 2) : 0;
      inj_lvl  = int'($urandom % 4);
      gen_walk(e, b, 13, 52, leaf_lvl, inj, inj_lvl);
      run_walk(e, b, 13, 52, ($urandom % 8 == 0));
    end

    chk(overlap_err == 0, "R8 no request while outstanding", 64'(overlap_err), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule